// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator with Phase Alignment

This block takes a fast reference clock and derives two slower clocks from it. The processor clock runs at one third of the reference rate. It is high for one reference period and low for the next two. The peripheral clock runs at half the processor clock rate and changes level only when the processor clock falls. Everything is produced from flops clocked on the reference, so both outputs are free of glitches.

An alignment input lets several copies of the block run in step. The block ignores a short glitch on this input. When the input is held high, the divider parks in its high phase and the peripheral clock parks low. Counting restarts from a known phase once the input is released. A reset request is passed through a short synchronizer that advances only on processor clock falling edges. The reset output therefore always lines up with the processor clock.

A local synchronous, active-high block reset puts every flop into a defined state.

Top module: `tri_phase_clkgen`

## Requirements
- R1: With no hold active, `cpu_clk` repeats the pattern high for one `ref_clk` cycle and then low for two `ref_clk` cycles. Its period is three reference cycles.
- R2: `per_clk` toggles on exactly those `ref_clk` edges where `cpu_clk` goes from high to low. At no other time does it change, except on a hold or a block reset. Its period is six reference cycles.
- R3: `sync_in` is registered on `ref_clk`. It takes effect only after it has been sampled high on two consecutive edges. A pulse that is seen high on a single edge changes neither output.
- R4: While the hold is in effect, `cpu_clk` stays high (the divider is at phase 0) and `per_clk` stays low. On the first edge at which the hold has ended, `cpu_clk` falls and `per_clk` rises.
- R5: `rst_out` is `rst_req_in` delayed through two stages. Both stages advance only on `cpu_clk` falling edges, and `rst_out` changes at no other time.
- R6: While `rst` is high at a `ref_clk` edge, the block goes to this state: `cpu_clk` = 1, `per_clk` = 0, `rst_out` = 1, and the alignment history is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high block reset |
| sync_in | input | 1 | Phase alignment request; must be high on two consecutive edges to take effect |
| rst_req_in | input | 1 | Asynchronous reset request to be synchronized |
| cpu_clk | output | 1 | Reference divided by three, one-third high |
| per_clk | output | 1 | Processor clock divided by two |
| rst_out | output | 1 | Reset request aligned to processor clock falling edges |

## Verification
The assertions assume that `sync_in` and `rst_req_in` are stable around every rising edge of `ref_clk`. They also assume that `rst` is applied synchronously. The bench meets this by changing every input only on the falling reference edge. The bench covers the following alignment cases:
- a pulse of one cycle, which must be ignored;
- a pulse of exactly two cycles, which is the shortest that takes effect;
- a long hold, released at different divider phases.

The reset request is toggled with several spacings, so that both the two-stage delay and the dependence on falling edges are exercised.

// File: rtl/tri_phase_pkg.sv
package tri_phase_pkg;

    localparam int DIV_RATIO = 3;

    // one-hot divider phase, bit 0 is the high phase of cpu_clk
    typedef logic [DIV_RATIO-1:0] phase_t;

    localparam phase_t PHASE_HIGH = phase_t'(1);

    typedef struct packed {
        logic hold;      // alignment hold in effect
        logic fall_en;   // this edge moves cpu_clk from high to low
    } div_ctl_t;

    function automatic phase_t phase_advance(input phase_t p);
        return {p[DIV_RATIO-2:0], p[DIV_RATIO-1]};
    endfunction

endpackage

// File: rtl/sync_filter.sv
module sync_filter #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic hold
);
    logic [STAGES-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[STAGES-2:0], sync_in};
    end

    assign hold = &hist;

    p_hold_needs_history_r3: assert property (@(posedge clk) disable iff (rst)
        hold |-> $past(sync_in));
endmodule

// File: rtl/div3_core.sv
module div3_core
    import tri_phase_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    output logic     cpu_clk,
    output div_ctl_t ctl
);
    phase_t phase;

    always_ff @(posedge clk) begin
        if (rst || hold) phase <= PHASE_HIGH;
        else             phase <= phase_advance(phase);
    end

    assign cpu_clk     = phase[0];
    assign ctl.hold    = hold;
    assign ctl.fall_en = phase[0] && !hold && !rst;

    p_high_one_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk && !hold) |=> !cpu_clk);
    p_low_two_cycles_r1: assert property (@(posedge clk) disable iff (rst)
        ($fell(cpu_clk) && !hold) |=> !cpu_clk);
    p_hold_parks_high_r4: assert property (@(posedge clk) disable iff (rst)
        hold |=> cpu_clk);
endmodule

// File: rtl/per_div2.sv
module per_div2
    import tri_phase_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_ctl_t ctl,
    output logic     per_clk
);
    always_ff @(posedge clk) begin
        if (rst || ctl.hold) per_clk <= 1'b0;
        else if (ctl.fall_en) per_clk <= ~per_clk;
    end

    p_per_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctl.fall_en && !ctl.hold) |=> $stable(per_clk));
    p_per_parked_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.hold |=> !per_clk);
endmodule

// File: rtl/rst_sync.sv
module rst_sync
    import tri_phase_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  div_ctl_t ctl,
    input  logic     req,
    output logic     rst_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)              chain <= '1;
        else if (ctl.fall_en) chain <= {chain[STAGES-2:0], req};
    end

    assign rst_out = chain[STAGES-1];

    p_rst_only_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !ctl.fall_en |=> $stable(rst_out));
endmodule

// File: rtl/tri_phase_clkgen.sv
module tri_phase_clkgen
    import tri_phase_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_STAGES  = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic sync_in,
    input  logic rst_req_in,
    output logic cpu_clk,
    output logic per_clk,
    output logic rst_out
);
    logic     hold;
    div_ctl_t ctl;

    sync_filter #(.STAGES(SYNC_STAGES)) u_filter (
        .clk(ref_clk), .rst(rst), .sync_in(sync_in), .hold(hold)
    );

    div3_core u_core (
        .clk(ref_clk), .rst(rst), .hold(hold), .cpu_clk(cpu_clk), .ctl(ctl)
    );

    per_div2 u_per (
        .clk(ref_clk), .rst(rst), .ctl(ctl), .per_clk(per_clk)
    );

    rst_sync #(.STAGES(RST_STAGES)) u_rst (
        .clk(ref_clk), .rst(rst), .ctl(ctl), .req(rst_req_in), .rst_out(rst_out)
    );

    p_reset_state_r6: assert property (@(posedge ref_clk)
        $past(rst) |-> (cpu_clk && !per_clk && rst_out));
endmodule

// File: tb/tri_phase_clkgen_bench.sv
`timescale 1ns/1ps
module tri_phase_clkgen_bench;
    logic ref_clk = 1'b0;
    logic rst = 1'b1, sync_in = 1'b0, rst_req_in = 1'b0;
    logic cpu_clk, per_clk, rst_out;

    int checks = 0, errors = 0, cycles = 0;
    string tag_c = "R1", tag_p = "R2";

    // behavioural model state
    int m_cnt = 0, m_per = 0, m_r1 = 1, m_r2 = 1, m_s1 = 0, m_s2 = 0;

    always #2 ref_clk = ~ref_clk;

    tri_phase_clkgen u_tri_phase_clkgen (
        .ref_clk(ref_clk), .rst(rst), .sync_in(sync_in), .rst_req_in(rst_req_in),
        .cpu_clk(cpu_clk), .per_clk(per_clk), .rst_out(rst_out)
    );

    task automatic check(string req, logic act, int exp);
        checks++;
        if (act !== exp[0]) begin
            errors++;
            $display("FAIL %s actual=%b expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic model_edge();
        bit hold, fall;
        hold = (m_s1 == 1) && (m_s2 == 1);
        fall = (m_cnt == 0) && !hold && !rst;
        if (rst) begin
            m_cnt = 0; m_per = 0; m_r1 = 1; m_r2 = 1; m_s1 = 0; m_s2 = 0;
        end else begin
            m_s2 = m_s1; m_s1 = sync_in;
            if (hold) begin m_cnt = 0; m_per = 0; end
            else begin
                m_cnt = (m_cnt + 1) % 3;
                if (fall) begin
                    m_per = 1 - m_per;
                    m_r2 = m_r1; m_r1 = rst_req_in;
                end
            end
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge ref_clk);
            model_edge();
            cycles++;
            @(negedge ref_clk);
            check(tag_c, cpu_clk, (m_cnt == 0) ? 1 : 0);
            check(tag_p, per_clk, m_per);
            check("R5", rst_out, m_r2);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tag_c = "R6"; tag_p = "R6";
        step(3);
        rst = 1'b0;
        tag_c = "R1"; tag_p = "R2";
        step(20);
        rst_req_in = 1'b1; step(4);
        rst_req_in = 1'b0; step(9);
        rst_req_in = 1'b1; step(13);
        // single-edge pulse must be ignored
        tag_c = "R3"; tag_p = "R3";
        sync_in = 1'b1; step(1);
        sync_in = 1'b0; step(8);
        // shortest effective pulse, then a long hold
        tag_c = "R4"; tag_p = "R4";
        sync_in = 1'b1; step(2);
        sync_in = 1'b0; step(7);
        step(1);
        sync_in = 1'b1; step(9);
        sync_in = 1'b0; step(10);
        step(2);
        sync_in = 1'b1; step(5);
        rst_req_in = 1'b0;
        sync_in = 1'b0; step(12);
        tag_c = "R1"; tag_p = "R2";
        step(15);
        // block reset mid-run
        tag_c = "R6"; tag_p = "R6";
        rst = 1'b1; step(2);
        rst = 1'b0;
        tag_c = "R1"; tag_p = "R2";
        step(12);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule